// File: doc/BRIEF.md
# Voted Configuration Word with Channel Steering

This block keeps the working configuration of a four-channel optical link front end. Three redundant command decoders each present a 16-bit command word. A per-bit two-out-of-three vote turns them into one word, so a single upset or faulty decoder cannot change the configuration. A slow serial test port can build the same 16-bit word one bit at a time and commit it on a load strobe. A mode input picks which of the two sources drives the active word.

The active word has three jobs. First, it writes 8-bit modulation drive codes into four per-channel code registers. Second, it routes one of three transmit inputs to the spare transmit output. Third, it sends the spare receive input into one chosen receive output in place of that channel's own signal. A power-on reset puts every drive code at a nominal value, so the link can run with no configuration at all. The steering paths are combinational from the registered word. The decoder inputs and the test port are sampled on the block clock.

Top module: `cfg_vote_steer`

## Requirements
- R1: When decoder mode is selected (`src_test`=0), bit i of `cfg_word` equals the majority of bit i of `cmd_a`, `cmd_b` and `cmd_c`, one clock after the inputs are sampled.
- R2: If any one of the three decoder words is corrupted while the other two agree, `cfg_word` stays equal to the agreeing value.
- R3: The test port shifts `tp_sdata` in on each rising edge of `tp_sclk`, most significant bit first. The shifted 16 bits replace the test-port word only on a rising edge of `tp_load`. Shifting alone leaves `cfg_word` unchanged.
- R4: With `src_test`=1, `cfg_word` follows the committed test-port word and ignores the decoder inputs. With `src_test`=0, it follows the voted decoder word.
- R5: While `rst_n` is low, `cfg_word` is 0 and every drive code in `mod_codes` is 213 (8'hD5).
- R6: The word is laid out as follows: bits [7:0] hold the code, bits [9:8] the channel, and bit 10 the write strobe. A 0-to-1 change of bit 10 writes the code into channel bits[9:8], at `mod_codes[ch*8 +: 8]`. Changing the code while bit 10 stays high writes nothing.
- R7: When bit 15 is 1 and bits [12:11]=s with s<3, `tx_out[3]` equals `tx_in[s]`. When s=3, `tx_out[3]` is 0. `tx_out[2:0]` always equals `tx_in`.
- R8: When bit 15 is 1 and bits [14:13]=d with d<3, `rx_out[d]` equals `rx_in[3]` and every other `rx_out[i]` equals `rx_in[i]`. When d=3, all outputs pass straight through.
- R9: When bit 15 is 0, `rx_out` equals `rx_in[2:0]` and `tx_out[3]` is 0, whatever bits [14:11] hold.
- R10: A code write changes only the addressed channel. The other three codes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| src_test | input | 1 | 1 selects the test-port word, 0 selects the voted decoder word |
| cmd_a | input | 16 | Command word from decoder copy A |
| cmd_b | input | 16 | Command word from decoder copy B |
| cmd_c | input | 16 | Command word from decoder copy C |
| tp_sclk | input | 1 | Test-port shift clock, sampled on clk |
| tp_sdata | input | 1 | Test-port serial data, MSB first |
| tp_load | input | 1 | Test-port commit strobe, rising edge active |
| tx_in | input | 3 | Transmit channel inputs 0..2 |
| tx_out | output | 4 | Transmit outputs; bit 3 is the spare |
| rx_in | input | 4 | Receive inputs; bit 3 is the spare |
| rx_out | output | 3 | Receive outputs to channels 0..2 |
| cfg_word | output | 16 | Active configuration word |
| mod_codes | output | 32 | Four 8-bit drive codes, channel i at [i*8 +: 8] |

## Verification
The hardest condition to reach is a write that must not happen. The strobe bit stays high while the code field changes, and no write may follow. The stimulus therefore writes a channel, then moves the code with the strobe still set, then clears the strobe, checking all four codes after each step. A second hard case is a test-port load that lands while the decoders are also changing. The bench shifts a full word with the test port selected but not yet committed, and checks that the active word is still the old one. Only then does it pulse the load and swing the decoder inputs. The bench sweeps every combination of enable, transmit source and receive destination with complementary input patterns, so a wrong select cannot pass by accident.

// File: rtl/cfg_vs_pkg.sv
package cfg_vs_pkg;

  localparam int CFG_W  = 16;
  localparam int CODE_W = 8;
  localparam int N_TX   = 4;
  localparam int N_RX   = 4;
  localparam int CH_W   = $clog2(N_TX);
  localparam int TXS_W  = $clog2(N_TX);
  localparam int RXD_W  = $clog2(N_RX);

  localparam logic [CODE_W-1:0] CODE_NOMINAL = 8'd213;

  // Field layout of the active word, most significant field first.
  typedef struct packed {
    logic             steer_en;
    logic [RXD_W-1:0] rx_dst;
    logic [TXS_W-1:0] tx_src;
    logic             wr_strobe;
    logic [CH_W-1:0]  wr_chan;
    logic [CODE_W-1:0] wr_code;
  } cfg_fields_t;

  // Two-out-of-three vote on one bit.
  function automatic logic vote_bit(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Pick one code from a flat code vector.
  function automatic logic [CODE_W-1:0] code_at(input logic [N_TX*CODE_W-1:0] codes,
                                                input logic [CH_W-1:0] ch);
    return codes[ch*CODE_W +: CODE_W];
  endfunction

endpackage

// File: rtl/cfg_majority.sv
module cfg_majority #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] voted
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign voted[i] = cfg_vs_pkg::vote_bit(in_a[i], in_b[i], in_c[i]);
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdata,
  input  logic         load,
  output logic [W-1:0] word_o,
  output logic         shift_fire,
  output logic         load_fire
);
  localparam int SYNC = 2;

  logic [SYNC:0]   sclk_s;
  logic [SYNC:0]   load_s;
  logic [SYNC-1:0] sdata_s;
  logic [W-1:0]    shreg;
  logic [W-1:0]    held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s  <= '0;
      load_s  <= '0;
      sdata_s <= '0;
    end else begin
      sclk_s  <= {sclk_s[SYNC-1:0], sclk};
      load_s  <= {load_s[SYNC-1:0], load};
      sdata_s <= {sdata_s[SYNC-2:0], sdata};
    end
  end

  assign shift_fire = sclk_s[SYNC-1] & ~sclk_s[SYNC];
  assign load_fire  = load_s[SYNC-1] & ~load_s[SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      held  <= '0;
    end else begin
      if (shift_fire) shreg <= {shreg[W-2:0], sdata_s[SYNC-1]};
      if (load_fire)  held  <= shreg;
    end
  end

  assign word_o = held;
endmodule

// File: rtl/cfg_dac_bank.sv
module cfg_dac_bank #(
  parameter int                N    = 4,
  parameter int                CW   = 8,
  parameter int                CHW  = 2,
  parameter logic [CW-1:0]     DEF  = 8'd213
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [CHW-1:0]  chan,
  input  logic [CW-1:0]   code,
  output logic [N*CW-1:0] codes_o,
  output logic            write_fire
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign write_fire = strobe & ~strobe_q;

  for (genvar i = 0; i < N; i++) begin : g_chan
    logic [CW-1:0] level_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               level_q <= DEF;
      else if (write_fire && chan == CHW'(i))   level_q <= code;
    end
    assign codes_o[i*CW +: CW] = level_q;
  end
endmodule

// File: rtl/cfg_steer.sv
module cfg_steer #(
  parameter int N_TX  = 4,
  parameter int N_RX  = 4,
  parameter int TXS_W = 2,
  parameter int RXD_W = 2
) (
  input  logic             en,
  input  logic [TXS_W-1:0] tx_src,
  input  logic [RXD_W-1:0] rx_dst,
  input  logic [N_TX-2:0]  tx_in,
  output logic [N_TX-1:0]  tx_out,
  input  logic [N_RX-1:0]  rx_in,
  output logic [N_RX-2:0]  rx_out
);
  localparam int TX_SPARE = N_TX - 1;
  localparam int RX_SPARE = N_RX - 1;

  logic tx_spare_val;

  for (genvar i = 0; i < TX_SPARE; i++) begin : g_tx
    assign tx_out[i] = tx_in[i];
  end

  always_comb begin
    tx_spare_val = 1'b0;
    for (int j = 0; j < TX_SPARE; j++) begin
      if (en && tx_src == TXS_W'(j)) tx_spare_val = tx_in[j];
    end
  end
  assign tx_out[TX_SPARE] = tx_spare_val;

  for (genvar i = 0; i < RX_SPARE; i++) begin : g_rx
    assign rx_out[i] = (en && rx_dst == RXD_W'(i)) ? rx_in[RX_SPARE] : rx_in[i];
  end
endmodule

// File: rtl/cfg_vote_steer.sv
module cfg_vote_steer
  import cfg_vs_pkg::*;
#(
  parameter int W      = cfg_vs_pkg::CFG_W,
  parameter int NTX    = cfg_vs_pkg::N_TX,
  parameter int NRX    = cfg_vs_pkg::N_RX,
  parameter int CODEW  = cfg_vs_pkg::CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_test,
  input  logic [W-1:0]         cmd_a,
  input  logic [W-1:0]         cmd_b,
  input  logic [W-1:0]         cmd_c,
  input  logic                 tp_sclk,
  input  logic                 tp_sdata,
  input  logic                 tp_load,
  input  logic [NTX-2:0]       tx_in,
  output logic [NTX-1:0]       tx_out,
  input  logic [NRX-1:0]       rx_in,
  output logic [NRX-2:0]       rx_out,
  output logic [W-1:0]         cfg_word,
  output logic [NTX*CODEW-1:0] mod_codes
);
  logic [W-1:0] voted_word;
  logic [W-1:0] tp_word;
  logic [W-1:0] word_q;
  logic         tp_shift_fire;
  logic         tp_load_fire;
  logic         dac_write_fire;
  cfg_fields_t  f;

  cfg_majority #(.W(W)) i_vote (
    .in_a  (cmd_a),
    .in_b  (cmd_b),
    .in_c  (cmd_c),
    .voted (voted_word)
  );

  cfg_serial_port #(.W(W)) i_tport (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (tp_sclk),
    .sdata      (tp_sdata),
    .load       (tp_load),
    .word_o     (tp_word),
    .shift_fire (tp_shift_fire),
    .load_fire  (tp_load_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= src_test ? tp_word : voted_word;
  end

  assign f        = cfg_fields_t'(word_q);
  assign cfg_word = word_q;

  cfg_dac_bank #(
    .N   (NTX),
    .CW  (CODEW),
    .CHW (CH_W),
    .DEF (CODE_NOMINAL)
  ) i_dac (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (f.wr_strobe),
    .chan       (f.wr_chan),
    .code       (f.wr_code),
    .codes_o    (mod_codes),
    .write_fire (dac_write_fire)
  );

  cfg_steer #(
    .N_TX  (NTX),
    .N_RX  (NRX),
    .TXS_W (TXS_W),
    .RXD_W (RXD_W)
  ) i_steer (
    .en     (f.steer_en),
    .tx_src (f.tx_src),
    .rx_dst (f.rx_dst),
    .tx_in  (tx_in),
    .tx_out (tx_out),
    .rx_in  (rx_in),
    .rx_out (rx_out)
  );
endmodule

// File: rtl/cfg_vote_steer_chk.sv
module cfg_vote_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_test,
  input logic [15:0] cmd_a,
  input logic [15:0] cmd_b,
  input logic [15:0] cmd_c,
  input logic [2:0]  tx_in,
  input logic [3:0]  tx_out,
  input logic [3:0]  rx_in,
  input logic [2:0]  rx_out,
  input logic [15:0] cfg_word,
  input logic [31:0] mod_codes,
  input logic        dac_write
);
  function automatic logic [7:0] code_of(input logic [31:0] c, input logic [1:0] ch);
    return c[ch*8 +: 8];
  endfunction

  // R1
  vote_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_test && cmd_a == cmd_b) |=> cfg_word == $past(cmd_a));

  // R2
  vote_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_test && cmd_b == cmd_c && cmd_a != cmd_b) |=> cfg_word == $past(cmd_b));

  // R5
  reset_codes_chk: assert property (@(posedge clk)
    !rst_n |-> (mod_codes == {4{8'd213}} && cfg_word == 16'h0000));

  // R6
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_word[10]) |-> dac_write);

  // R6
  write_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_write |=> code_of(mod_codes, $past(cfg_word[9:8])) == $past(cfg_word[7:0]));

  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_write |=> $stable(mod_codes));

  // R7
  tx_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[15] && cfg_word[12:11] != 2'd3) |-> tx_out[3] == tx_in[cfg_word[12:11]]);

  // R8
  rx_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[15] && cfg_word[14:13] != 2'd3) |-> rx_out[cfg_word[14:13]] == rx_in[3]);

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[15] |-> (tx_out[3] == 1'b0 && rx_out == rx_in[2:0]));
endmodule

bind cfg_vote_steer cfg_vote_steer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_test  (src_test),
  .cmd_a     (cmd_a),
  .cmd_b     (cmd_b),
  .cmd_c     (cmd_c),
  .tx_in     (tx_in),
  .tx_out    (tx_out),
  .rx_in     (rx_in),
  .rx_out    (rx_out),
  .cfg_word  (cfg_word),
  .mod_codes (mod_codes),
  .dac_write (dac_write_fire)
);

// File: tb/test_cfg_vote_steer.sv
`timescale 1ns/1ps
module test_cfg_vote_steer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        src_test = 1'b0;
  logic [15:0] cmd_a = '0, cmd_b = '0, cmd_c = '0;
  logic        tp_sclk = 1'b0, tp_sdata = 1'b0, tp_load = 1'b0;
  logic [2:0]  tx_in = '0;
  logic [3:0]  tx_out;
  logic [3:0]  rx_in = '0;
  logic [2:0]  rx_out;
  logic [15:0] cfg_word;
  logic [31:0] mod_codes;

  always #2.5 clk = ~clk;

  cfg_vote_steer i_cfg_vote_steer (
    .clk(clk), .rst_n(rst_n), .src_test(src_test),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c),
    .tp_sclk(tp_sclk), .tp_sdata(tp_sdata), .tp_load(tp_load),
    .tx_in(tx_in), .tx_out(tx_out), .rx_in(rx_in), .rx_out(rx_out),
    .cfg_word(cfg_word), .mod_codes(mod_codes)
  );

  typedef struct {
    string       tag;
    logic [15:0] word;
    logic [31:0] codes;
    logic [3:0]  tx;
    logic [2:0]  rx;
  } exp_t;

  exp_t sb[$];
  int   vectors = 0;
  int   miscompares = 0;

  // reference model state
  logic [15:0] m_word = '0;
  logic [15:0] m_tp = '0;
  logic [7:0]  m_code [4];

  function automatic logic [15:0] ref_vote(input logic [15:0] a, b, c);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      int ones;
      ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (ones >= 2);
    end
    return r;
  endfunction

  function automatic logic [15:0] mk(input logic en, input logic [1:0] rxd, input logic [1:0] txs,
                                     input logic stb, input logic [1:0] ch, input logic [7:0] code);
    return {en, rxd, txs, stb, ch, code};
  endfunction

  function automatic logic [3:0] ref_tx(input logic [15:0] w, input logic [2:0] ti);
    logic sp;
    sp = 1'b0;
    if (w[15]) begin
      case (w[12:11])
        2'd0: sp = ti[0];
        2'd1: sp = ti[1];
        2'd2: sp = ti[2];
        default: sp = 1'b0;
      endcase
    end
    return {sp, ti};
  endfunction

  function automatic logic [2:0] ref_rx(input logic [15:0] w, input logic [3:0] ri);
    logic [2:0] o;
    o = ri[2:0];
    if (w[15] && w[14:13] != 2'd3) o[w[14:13]] = ri[3];
    return o;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag   = tag;
    e.word  = m_word;
    e.codes = {m_code[3], m_code[2], m_code[1], m_code[0]};
    e.tx    = ref_tx(m_word, tx_in);
    e.rx    = ref_rx(m_word, rx_in);
    sb.push_back(e);
    while (sb.size() != 0) @(posedge clk);
  endtask

  // let the design settle and advance the model by one word transition
  task automatic settle(input string tag);
    logic [15:0] nw;
    repeat (3) @(posedge clk);
    nw = src_test ? m_tp : ref_vote(cmd_a, cmd_b, cmd_c);
    if (nw[10] && !m_word[10]) m_code[nw[9:8]] = nw[7:0];
    m_word = nw;
    push(tag);
  endtask

  task automatic drive_cmd(input logic [15:0] a, b, c, input string tag);
    @(negedge clk);
    cmd_a = a; cmd_b = b; cmd_c = c;
    settle(tag);
  endtask

  task automatic shift_word(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      tp_sdata = v[i];
      tp_sclk  = 1'b0;
      repeat (4) @(negedge clk);
      tp_sclk  = 1'b1;
      repeat (4) @(negedge clk);
    end
    tp_sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load(input logic [15:0] shifted);
    @(negedge clk);
    tp_load = 1'b1;
    repeat (4) @(negedge clk);
    tp_load = 1'b0;
    m_tp = shifted;
  endtask

  // monitor: compare popped expectations away from the active edge
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (cfg_word !== e.word) begin
        miscompares++;
        $display("FAIL %s cfg_word actual %h expected %h", e.tag, cfg_word, e.word);
      end
      if (mod_codes !== e.codes) begin
        miscompares++;
        $display("FAIL %s mod_codes actual %h expected %h", e.tag, mod_codes, e.codes);
      end
      if (tx_out !== e.tx) begin
        miscompares++;
        $display("FAIL %s tx_out actual %b expected %b", e.tag, tx_out, e.tx);
      end
      if (rx_out !== e.rx) begin
        miscompares++;
        $display("FAIL %s rx_out actual %b expected %b", e.tag, rx_out, e.rx);
      end
    end
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_code[i] = 8'd213;

    // R5: reset defaults observed while reset is held
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    push("R5 reset");
    @(negedge clk) rst_n = 1'b1;
    push("R5 after release");

    // R1: agreeing and bitwise-mixed decoder words
    drive_cmd(16'h1234, 16'h1234, 16'h1234, "R1 agree");
    drive_cmd(16'h0321, 16'h0321, 16'h0321, "R1 agree2");
    // R1 + R6: mixed words vote to 0x0FF0: strobe rises, channel 3 gets 0xF0
    drive_cmd(16'hFF00, 16'h0FF0, 16'h00FF, "R1 mixed vote");
    drive_cmd(16'h0000, 16'h0000, 16'h0000, "R1 clear");

    // R2: one corrupted copy at a time
    drive_cmd(16'h2345, 16'h2345, 16'hDCBA, "R2 c corrupt");
    drive_cmd(16'hFFFF, 16'h2345, 16'h2345, "R2 a corrupt");
    drive_cmd(16'h2345, 16'h0000, 16'h2345, "R2 b corrupt");

    // R6 / R10: write channel 1, then move code with strobe held high
    drive_cmd(mk(0,0,0,0,2'd1,8'h5A), mk(0,0,0,0,2'd1,8'h5A), mk(0,0,0,0,2'd1,8'h5A), "R6 setup");
    drive_cmd(mk(0,0,0,1,2'd1,8'h5A), mk(0,0,0,1,2'd1,8'h5A), mk(0,0,0,1,2'd1,8'h5A), "R6 R10 write ch1");
    drive_cmd(mk(0,0,0,1,2'd1,8'h11), mk(0,0,0,1,2'd1,8'h11), mk(0,0,0,1,2'd1,8'h11), "R6 held strobe no write");
    drive_cmd(mk(0,0,0,1,2'd0,8'h22), mk(0,0,0,1,2'd0,8'h22), mk(0,0,0,1,2'd0,8'h22), "R6 held strobe chan move");
    drive_cmd(mk(0,0,0,0,2'd0,8'h22), mk(0,0,0,0,2'd0,8'h22), mk(0,0,0,0,2'd0,8'h22), "R6 strobe low");
    drive_cmd(mk(0,0,0,1,2'd0,8'h22), mk(0,0,0,1,2'd0,8'h22), mk(0,0,0,1,2'd0,8'h22), "R6 R10 write ch0");
    drive_cmd(16'h0000, 16'h0000, 16'h0000, "R6 idle");

    // R7 / R8 / R9: every steering combination, two complementary patterns
    for (int en = 0; en < 2; en++) begin
      for (int rd = 0; rd < 4; rd++) begin
        for (int ts = 0; ts < 4; ts++) begin
          logic [15:0] w;
          w = mk(en[0], rd[1:0], ts[1:0], 1'b0, 2'd0, 8'h00);
          @(negedge clk);
          tx_in = 3'b001 << (ts % 3);
          rx_in = 4'b1000;
          cmd_a = w; cmd_b = w; cmd_c = w;
          settle(en != 0 ? "R7 R8 steer" : "R9 bypass");
          @(negedge clk);
          tx_in = ~(3'b001 << (ts % 3));
          rx_in = 4'b0111;
          settle(en != 0 ? "R7 R8 steer inv" : "R9 bypass inv");
        end
      end
    end

    // R4 / R3: switch to the test port, shift without load, then load
    drive_cmd(16'h0000, 16'h0000, 16'h0000, "R4 decoder idle");
    @(negedge clk) src_test = 1'b1;
    settle("R4 test source before load");
    shift_word(16'hA6C3);
    settle("R3 shifted not loaded");
    pulse_load(16'hA6C3);
    settle("R3 R6 loaded word");
    drive_cmd(16'h7777, 16'h7777, 16'h7777, "R4 decoders ignored");
    shift_word(16'h1B05);
    pulse_load(16'h1B05);
    settle("R3 second load");
    @(negedge clk) src_test = 1'b0;
    settle("R4 back to decoders");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule